// File: doc/BRIEF.md
# Bus Region Decoder with Boot Overlay

This block decodes every access of a 24-bit-address, 16-bit-data processor bus. The address space is cut into 64 regions of 256 KB, indexed by the top six address bits. Each region is classed as writable RAM, read-only ROM or non-memory. For memory regions it raises a memory select together with a write permission. For non-memory accesses it decodes a window holding two byte-wide peripheral chips and a window of custom chip registers. Any access that hits none of these reads back an open-bus value.

The two peripherals sit on opposite byte lanes. The first uses the upper data byte, the second the lower byte, and each is chosen by an active-low address bit, so one access can reach both. Read data from the peripheral window starts as all ones, and each selected chip overwrites its own lane. A single overlay flag, set by reset and later loaded from a port output bit, places ROM over the lowest 512 KB so the processor can fetch its reset vectors. While the flag is cleared, that range is RAM.

The decode is purely combinational. Only the overlay flag is a register. Memories and peripherals lie outside the block, and their read data comes in on input ports.

Top module: `bus_region_decoder`

## Requirements
- R1: Addresses 0xFC0000 to 0xFFFFFF (region 63) with the strobe high give mem_sel=1 and mem_rom=1, and rdata equals mem_rdata.
- R2: After reset the overlay flag is 1, and addresses 0x000000 to 0x07FFFF (regions 0 and 1) then decode as ROM: mem_sel=1, mem_rom=1, mem_we=0.
- R3: With the overlay flag at 0, regions 0 and 1 decode as RAM: mem_sel=1, mem_rom=0, mem_we equal to the inverse of rd (rd=1 read, rd=0 write).
- R4: When ovl_load is high at a rising clock edge, the overlay flag takes ovl_bit from that edge on. When ovl_load is low, the flag holds.
- R5: A peripheral access is an access with (addr & 0xE00000) == 0xA00000. While either peripheral is selected, per_reg equals addr[11:8], otherwise it is 0.
- R6: In the peripheral window, pa_sel=1 when addr[12]=0 and pb_sel=1 when addr[13]=0. per_we is the inverse of rd while either is selected. pa_wdata=wdata[15:8] and pb_wdata=wdata[7:0].
- R7: Peripheral read data is 0xFFFF, with rdata[15:8] replaced by pa_rdata when pa_sel=1 and rdata[7:0] replaced by pb_rdata when pb_sel=1.
- R8: Addresses 0xDFF000 through 0xDFF1BE raise cust_sel, and rdata equals cust_rdata.
- R9: Any other access, including a peripheral-window access with addr[13:12]=2'b11, raises no select and returns rdata=0xFFFF.
- R10: With as=0 no select is raised and rdata is 0xFFFF. Peripheral and custom selects also need bsel=1. Memory selects need only as=1.
- R11: A write to a ROM region leaves mem_we=0, so the memory cannot be changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overlay flag |
| rst_n | input | 1 | Active-low reset, sets the overlay flag |
| addr | input | 24 | Byte address |
| rd | input | 1 | 1 read, 0 write |
| as | input | 1 | Address strobe |
| bsel | input | 1 | Byte or word data select |
| wdata | input | 16 | Write data |
| ovl_load | input | 1 | Load strobe for the overlay flag |
| ovl_bit | input | 1 | New overlay value (peripheral port bit 0) |
| mem_rdata | input | 16 | Read data from RAM/ROM |
| pa_rdata | input | 8 | Read data from first peripheral |
| pb_rdata | input | 8 | Read data from second peripheral |
| cust_rdata | input | 16 | Read data from custom registers |
| mem_sel | output | 1 | Memory region selected |
| mem_rom | output | 1 | Selected region is ROM |
| mem_we | output | 1 | Memory write permitted |
| pa_sel | output | 1 | First peripheral select |
| pb_sel | output | 1 | Second peripheral select |
| per_we | output | 1 | Peripheral write |
| per_reg | output | 4 | Peripheral register index |
| pa_wdata | output | 8 | Write byte for first peripheral |
| pb_wdata | output | 8 | Write byte for second peripheral |
| cust_sel | output | 1 | Custom register window select |
| rdata | output | 16 | Merged read data |
| ovl_state | output | 1 | Current overlay flag |

## Verification
The only state is the overlay flag. A wrong value shows at once as regions 0 and 1 decoding with the wrong class: mem_rom and mem_we flip on the same access that follows. ovl_state exposes the flag directly, so a failed load is visible one edge after ovl_load. Every other fault is a decode error. It shows in the same cycle on the selects or rdata for some address, which is why the bench sweeps all regions under both overlay states and every peripheral lane pattern.

// File: rtl/bus_region_decoder.sv
module bus_region_decoder #(
  parameter int          AW           = 24,
  parameter int          DW           = 16,
  parameter int          RGN_BITS     = 6,
  parameter int          LOW_RGNS     = 2,
  parameter int          ROM_RGN_LO   = 63,
  parameter logic [23:0] PER_MASK     = 24'hE00000,
  parameter logic [23:0] PER_MATCH    = 24'hA00000,
  parameter int          PA_SEL_BIT   = 12,
  parameter int          PB_SEL_BIT   = 13,
  parameter int          REG_LSB      = 8,
  parameter int          REG_W        = 4,
  parameter logic [23:0] CUST_LO      = 24'hDFF000,
  parameter logic [23:0] CUST_HI      = 24'hDFF1BE,
  parameter logic [15:0] OPEN_BUS     = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             rd,
  input  logic             as,
  input  logic             bsel,
  input  logic [DW-1:0]    wdata,
  input  logic             ovl_load,
  input  logic             ovl_bit,
  input  logic [DW-1:0]    mem_rdata,
  input  logic [DW/2-1:0]  pa_rdata,
  input  logic [DW/2-1:0]  pb_rdata,
  input  logic [DW-1:0]    cust_rdata,
  output logic             mem_sel,
  output logic             mem_rom,
  output logic             mem_we,
  output logic             pa_sel,
  output logic             pb_sel,
  output logic             per_we,
  output logic [REG_W-1:0] per_reg,
  output logic [DW/2-1:0]  pa_wdata,
  output logic [DW/2-1:0]  pb_wdata,
  output logic             cust_sel,
  output logic [DW-1:0]    rdata,
  output logic             ovl_state
);
  localparam int NRGN = 1 << RGN_BITS;
  localparam int LANE = DW / 2;
  localparam logic [1:0] K_NONE = 2'd0, K_ROM = 2'd1, K_LOW = 2'd2;

  logic ovl_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ovl_q <= 1'b1;
    else if (ovl_load) ovl_q <= ovl_bit;
  assign ovl_state = ovl_q;

  logic [1:0] rgn_kind [NRGN];
  for (genvar g = 0; g < NRGN; g++) begin : g_rgn
    assign rgn_kind[g] = (g >= ROM_RGN_LO) ? K_ROM : (g < LOW_RGNS) ? K_LOW : K_NONE;
  end

  logic [RGN_BITS-1:0] rgn;
  logic [1:0] kind;
  logic is_rom, is_ram, per_hit, per_any, cust_hit, qual;
  assign rgn  = addr[AW-1 -: RGN_BITS];
  assign kind = rgn_kind[rgn];
  assign qual = as & bsel;

  assign is_rom = (kind == K_ROM) | ((kind == K_LOW) & ovl_q);
  assign is_ram = (kind == K_LOW) & ~ovl_q;

  assign mem_sel = as & (is_rom | is_ram);
  assign mem_rom = as & is_rom;
  assign mem_we  = as & is_ram & ~rd;

  assign per_hit  = qual & (kind == K_NONE) & ((addr & PER_MASK) == PER_MATCH);
  assign pa_sel   = per_hit & ~addr[PA_SEL_BIT];
  assign pb_sel   = per_hit & ~addr[PB_SEL_BIT];
  assign per_any  = pa_sel | pb_sel;
  assign per_we   = per_any & ~rd;
  assign per_reg  = per_any ? addr[REG_LSB +: REG_W] : '0;
  assign pa_wdata = wdata[DW-1 -: LANE];
  assign pb_wdata = wdata[LANE-1:0];

  assign cust_hit = qual & (kind == K_NONE) & ~per_hit & (addr >= CUST_LO) & (addr <= CUST_HI);
  assign cust_sel = cust_hit;

  always_comb begin
    rdata = OPEN_BUS;
    if (mem_sel) rdata = mem_rdata;
    else if (per_any) begin
      if (pa_sel) rdata[DW-1 -: LANE] = pa_rdata;
      if (pb_sel) rdata[LANE-1:0]     = pb_rdata;
    end
    else if (cust_hit) rdata = cust_rdata;
  end

  p_rom_write_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_rom);
  p_single_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_sel, per_any, cust_sel}));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !as |-> !(mem_sel | pa_sel | pb_sel | cust_sel));
  p_ovl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_load |=> (ovl_state == $past(ovl_bit)));
  p_ovl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_load |=> $stable(ovl_state));
  p_open_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_sel | pa_sel | pb_sel | cust_sel) |-> rdata == OPEN_BUS);
  p_lane_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_sel && !pb_sel) |-> rdata[LANE-1:0] == OPEN_BUS[LANE-1:0]);
endmodule

// File: tb/test_bus_region_decoder.sv
module test_bus_region_decoder;
  logic clk = 0, rst_n = 0;
  logic [23:0] addr = 0;
  logic rd = 1, as = 0, bsel = 0, ovl_load = 0, ovl_bit = 0;
  logic [15:0] wdata = 16'hA55A;
  logic [15:0] mem_rdata = 16'h1234, cust_rdata = 16'hBEEF;
  logic [7:0] pa_rdata = 8'h5A, pb_rdata = 8'hC3;
  logic mem_sel, mem_rom, mem_we, pa_sel, pb_sel, per_we, cust_sel, ovl_state;
  logic [3:0] per_reg;
  logic [7:0] pa_wdata, pb_wdata;
  logic [15:0] rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_region_decoder i_bus_region_decoder (.*);

  function automatic logic [26:0] model(logic [23:0] a, logic r, logic s, logic b, logic ov);
    logic ms = 0, mr = 0, mw = 0, pa = 0, pb = 0, pw = 0, cs = 0;
    logic [3:0] rg = 0;
    logic [15:0] d = 16'hFFFF;
    int rgn = a >> 18;
    if (s) begin
      if (rgn == 63 || (rgn < 2 && ov)) begin ms = 1; mr = 1; d = mem_rdata; end
      else if (rgn < 2) begin ms = 1; mw = !r; d = mem_rdata; end
      else if (b && (a >> 21) == 5) begin
        pa = !a[12]; pb = !a[13];
        if (pa || pb) begin
          pw = !r; rg = a[11:8];
          d = {pa ? pa_rdata : 8'hFF, pb ? pb_rdata : 8'hFF};
        end
      end
      else if (b && a >= 24'hDFF000 && a <= 24'hDFF1BE) begin cs = 1; d = cust_rdata; end
    end
    return {ms, mr, mw, pa, pb, pw, rg, cs, d};
  endfunction

  function automatic string tag_of(logic [23:0] a, logic s, logic b);
    int rgn = a >> 18;
    if (!s) return "R10";
    if (rgn == 63) return "R1";
    if (rgn < 2) return "R3";
    if (!b) return "R10";
    if ((a >> 21) == 5) return "R6";
    if (a >= 24'hDFF000 && a <= 24'hDFF1BE) return "R8";
    return "R9";
  endfunction

  task automatic drive(logic [23:0] a, logic r, logic s, logic b);
    @(negedge clk);
    addr = a; rd = r; as = s; bsel = b;
    #2;
  endtask

  task automatic check(string tag);
    logic [26:0] act, exp;
    act = {mem_sel, mem_rom, mem_we, pa_sel, pb_sel, per_we, per_reg, cust_sel, rdata};
    exp = model(addr, rd, as, bsel, ovl_state);
    checks++;
    if (act !== exp || pa_wdata !== wdata[15:8] || pb_wdata !== wdata[7:0]) begin
      errors++;
      $display("FAIL %s addr=%h rd=%b act=%h exp=%h wd=%h/%h", tag, addr, rd, act, exp, pa_wdata, pb_wdata);
    end
  endtask

  task automatic expect_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic sweep(string rtag);
    logic [23:0] offs [3] = '{24'h000000, 24'h01F3FE, 24'h03EFFF};
    for (int r = 0; r < 64; r++)
      for (int o = 0; o < 3; o++)
        for (int w = 0; w < 2; w++) begin
          logic [23:0] a = (24'(r) << 18) | offs[o];
          drive(a, w[0], 1, 1);
          check((r < 2) ? rtag : tag_of(a, 1, 1));
        end
  endtask

  task automatic set_overlay(logic v);
    @(negedge clk); ovl_load = 1; ovl_bit = v;
    @(negedge clk); ovl_load = 0; ovl_bit = !v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    drive(24'h000000, 1, 1, 1);
    expect_bit("R2", ovl_state, 1'b1);
    check("R2");
    sweep("R2");
    drive(24'h040000, 0, 1, 1); check("R11");
    drive(24'hFC1000, 0, 1, 1); check("R11");
    drive(24'hFFFFFE, 0, 1, 0); check("R11");
    // R4: no change without load, then load one edge later
    drive(24'h000100, 0, 1, 1);
    ovl_bit = 0;
    @(negedge clk); #2;
    expect_bit("R4", ovl_state, 1'b1);
    ovl_load = 1;
    #2; check("R4");
    @(negedge clk); ovl_load = 0; #2;
    expect_bit("R4", ovl_state, 1'b0);
    check("R3");
    sweep("R3");
    // R5/R6/R7: peripheral window, all lane patterns and indices
    for (int hi = 0; hi < 4; hi++)
      for (int ri = 0; ri < 16; ri++)
        for (int w = 0; w < 2; w++) begin
          logic [23:0] a = 24'hA00000 | (24'(hi) << 21 & 24'h200000) | (24'(hi) << 12 & 24'h3000) | (24'(ri) << 8) | 24'(w);
          wdata = 16'(ri * 16'h1111 + hi);
          drive(a, w[0], 1, 1);
          check(ri[0] ? "R5" : (w[0] ? "R7" : "R6"));
        end
    pa_rdata = 8'h00; pb_rdata = 8'h7E;
    drive(24'hBFE001, 1, 1, 1); check("R7");
    drive(24'hBFD100, 1, 1, 1); check("R7");
    drive(24'hBFC200, 1, 1, 1); check("R7");
    drive(24'hBFF300, 1, 1, 1); check("R9");
    // R8 boundaries
    drive(24'hDFEFFF, 1, 1, 1); check("R9");
    drive(24'hDFF000, 1, 1, 1); check("R8");
    drive(24'hDFF09A, 0, 1, 1); check("R8");
    drive(24'hDFF1BE, 1, 1, 1); check("R8");
    drive(24'hDFF1BF, 1, 1, 1); check("R9");
    drive(24'hDFF1C0, 1, 1, 1); check("R9");
    drive(24'h200000, 1, 1, 1); check("R9");
    // R10 qualification
    drive(24'hBFE001, 1, 1, 0); check("R10");
    drive(24'hDFF000, 1, 1, 0); check("R10");
    drive(24'h000000, 0, 1, 0); check("R10");
    drive(24'h000000, 0, 0, 1); check("R10");
    drive(24'hBFE001, 0, 0, 1); check("R10");
    drive(24'hFC0000, 1, 0, 1); check("R10");
    set_overlay(1);
    #2; expect_bit("R4", ovl_state, 1'b1);
    drive(24'h07FFFE, 0, 1, 1); check("R11");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule